// File: doc/BRIEF.md
# Trace Message Packetizer with Framing Sideband

This block takes one debug trace message per request and emits it as a stream of fixed-width beats on a parallel data port. Each beat has a 2-bit framing code alongside it. The code says whether the beat is an ordinary transfer beat, the closing beat of one packet, or the closing beat of the whole message. The same code, with the data zeroed, also marks an idle port. A message is made of one or more packets. The first packet opens with a 6-bit type code and a 4-bit source identifier. Every packet may then carry a fixed-length field, followed by an optional variable-length field. A variable-length field is sent with only its significant bits and always closes its packet.

All bits of a packet are placed one after another, least significant bit first, and cut into beats of `BEAT_W` bits. The upper bits of a packet's closing beat that carry no packet bits are driven to zero. Input arrives on a ready/valid handshake. The block accepts a new request while it is idle, or during the final beat of the current message. A new message can therefore follow the previous one with no gap.

The controller has two states. `S_IDLE` drives the idle code and holds `in_ready` high. `S_SEND` emits beats. Its transitions are:
- IDLE→SEND, taken when a request is accepted.
- SEND→SEND "continue", which moves on to the next beat of the same packet.
- SEND→SEND "next packet", taken after a packet-closing beat.
- SEND→SEND "chain", taken when a new request is accepted on the final beat.
- SEND→IDLE, taken after the final beat when no request is pending.

Top module: `tm_packer`

## Requirements
- R1: After reset, and whenever no message is in progress, `out_frame` is 2'b11, `out_data` is zero and `in_ready` is 1.
- R2: The first beat of a message carries the type code in bits [5:0] and the source identifier in bits [9:6]. The bits of packet 0 continue from bit 10.
- R3: A packet's bit string is built from three parts, in this order:
  - the 10 header bits (packet 0 only),
  - the low bits of the fixed field,
  - the significant bits of the variable field, when it is enabled.

  Packet p's fixed field is `in_fix_data[p*FIX_W +: FIX_W]` with length `in_fix_len[p*FLW +: FLW]`. Its variable field is `in_var_data[p*VAR_W +: VAR_W]`, enabled by `in_var_en[p]`. Beat k of a packet carries string bits [k*BEAT_W +: BEAT_W].
- R4: The length of a variable field is the index of its highest set bit plus one. A field value of zero sends a single 0 bit.
- R5: A fixed length above `FIX_W` is treated as `FIX_W`. Fixed-field data bits at or above the fixed length are not sent.
- R6: Bits of a packet's closing beat that lie beyond the packet's length are zero. A packet of zero bits is sent as one all-zero beat.
- R7: Each beat carries one of three framing codes:
  - 2'b00 on every beat that does not close a packet,
  - 2'b01 on the closing beat of a packet that is not the last one,
  - 2'b11 on the closing beat of the last packet.
- R8: `in_pkt_cnt` gives the number of packets. A value of 0 is treated as 1, and a value above `MAX_PKT` is treated as `MAX_PKT`.
- R9: `in_ready` is high in idle and on the final beat of a message, and low on every other beat. A request presented while `in_ready` is low is held off and is sent unchanged later.
- R10: The first beat of an accepted message appears in the cycle after acceptance. A message accepted on a final beat follows it with no idle beat in between.
- R11: After a final beat with no request accepted, the next cycle is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Message request present |
| in_ready | output | 1 | Request accepted this cycle when `in_valid` is also high |
| in_type | input | 6 | Message type code |
| in_src | input | 4 | Source identifier |
| in_pkt_cnt | input | CNT_W (2) | Number of packets |
| in_fix_data | input | MAX_PKT*FIX_W (16) | Fixed field of each packet |
| in_fix_len | input | MAX_PKT*FLW (8) | Fixed field length of each packet |
| in_var_en | input | MAX_PKT (2) | Variable field present, one bit per packet |
| in_var_data | input | MAX_PKT*VAR_W (64) | Variable field of each packet |
| out_data | output | BEAT_W (12) | Beat data |
| out_frame | output | 2 | Framing code |

## Verification
The bench builds the block with `BEAT_W`=12, `MAX_PKT`=3, `FIX_W`=4 and `VAR_W`=12. With these values a packet holds at most 26 bits, so it is sent in one to three beats.

This configuration makes several sweeps cheap:
- every fixed length from 0 to 7, which includes the clamped values 5 to 7;
- both settings of the variable-field enable, on every packet index;
- variable values whose significant length ranges over 1 to 12 bits.

Together these reach every beat count, each framing code at each packet position, and zero-bit packets. Messages are sent both with idle gaps and back to back, while a pending request is held against a low `in_ready`.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int TYPE_W = 6;
    localparam int SRC_W  = 4;
    localparam int HDR_W  = TYPE_W + SRC_W;

    // framing codes; "end of message" shares its code with idle
    localparam logic [1:0] FRM_BUSY = 2'b00;
    localparam logic [1:0] FRM_EOP  = 2'b01;
    localparam logic [1:0] FRM_END  = 2'b11;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } state_t;
endpackage

// File: rtl/tm_sigbits.sv
module tm_sigbits #(
    parameter int W     = 32,
    parameter int LEN_W = 6
) (
    input  logic [W-1:0]     val,
    output logic [LEN_W-1:0] nbits
);
    // R4: significant length, minimum one bit
    always_comb begin
        nbits = LEN_W'(1);
        for (int i = 0; i < W; i++) begin
            if (val[i]) begin
                nbits = LEN_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/tm_pkt_build.sv
module tm_pkt_build #(
    parameter int FIX_W = 8,
    parameter int VAR_W = 32,
    parameter int FLW   = 4,
    parameter int VEC_W = 50,
    parameter int LEN_W = 6
) (
    input  logic                      first,
    input  logic [tm_pkg::HDR_W-1:0]  hdr,
    input  logic [FIX_W-1:0]          fix_data,
    input  logic [FLW-1:0]            fix_len,
    input  logic                      var_en,
    input  logic [VAR_W-1:0]          var_data,
    output logic [VEC_W-1:0]          vec,
    output logic [LEN_W-1:0]          len
);
    import tm_pkg::*;

    logic [LEN_W-1:0] var_len;
    logic [LEN_W-1:0] fix_eff;
    logic [LEN_W-1:0] hdr_len;
    logic [VEC_W-1:0] fix_part;
    logic [VEC_W-1:0] var_part;
    logic [VEC_W-1:0] hdr_part;

    tm_sigbits #(.W(VAR_W), .LEN_W(LEN_W)) u_sig (
        .val   (var_data),
        .nbits (var_len)
    );

    always_comb begin
        // R5: clamp the fixed length
        fix_eff  = (32'(fix_len) > FIX_W) ? LEN_W'(FIX_W) : LEN_W'(fix_len);
        hdr_len  = first ? LEN_W'(HDR_W) : '0;
        hdr_part = first ? VEC_W'(hdr) : '0;
        // R5/R6: bits above the fixed length are cleared
        fix_part = (VEC_W'(fix_data) & ~({VEC_W{1'b1}} << fix_eff)) << hdr_len;
        var_part = var_en ? (VEC_W'(var_data) << (hdr_len + fix_eff)) : '0;
        vec      = hdr_part | fix_part | var_part;
        len      = hdr_len + fix_eff + (var_en ? var_len : '0);
    end
endmodule

// File: rtl/tm_beat_fsm.sv
module tm_beat_fsm #(
    parameter int BEAT_W  = 12,
    parameter int MAX_PKT = 2,
    parameter int IDX_W   = 1,
    parameter int CNT_W   = 2,
    parameter int LEN_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CNT_W-1:0]     pkt_cnt,
    input  logic [LEN_W-1:0]     pkt_len,
    output logic                 in_ready,
    output logic                 take,
    output tm_pkg::state_t       state,
    output logic [IDX_W-1:0]     pkt_idx,
    output logic [LEN_W-1:0]     bit_off,
    output logic [1:0]           frame
);
    import tm_pkg::*;

    state_t           state_d;
    logic [IDX_W-1:0] idx_d;
    logic [LEN_W-1:0] off_d;
    logic [LEN_W-1:0] rem;
    logic             last_beat;
    logic             last_pkt;
    logic             end_msg;

    always_comb begin
        rem       = pkt_len - bit_off;
        last_beat = 32'(rem) <= 32'(BEAT_W);
        // R8: zero counts as one, overlarge counts stop at MAX_PKT
        last_pkt  = (32'(pkt_idx) + 1 >= 32'(pkt_cnt)) || (32'(pkt_idx) == MAX_PKT - 1);
        end_msg   = (state == S_SEND) && last_beat && last_pkt;
        // R9: accept in idle or on the final beat
        in_ready  = (state == S_IDLE) || end_msg;
        take      = in_valid && in_ready;
    end

    // next state
    always_comb begin
        state_d = state;
        idx_d   = pkt_idx;
        off_d   = bit_off;
        unique case (state)
            S_IDLE: begin
                if (take) begin
                    state_d = S_SEND;
                    idx_d   = '0;
                    off_d   = '0;
                end
            end
            S_SEND: begin
                if (!last_beat) begin
                    off_d = bit_off + LEN_W'(BEAT_W);
                end else if (!last_pkt) begin
                    idx_d = pkt_idx + IDX_W'(1);
                    off_d = '0;
                end else if (take) begin
                    idx_d = '0;                 // R10: chain with no gap
                    off_d = '0;
                end else begin
                    state_d = S_IDLE;           // R11
                    idx_d   = '0;
                    off_d   = '0;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            pkt_idx <= '0;
            bit_off <= '0;
        end else begin
            state   <= state_d;
            pkt_idx <= idx_d;
            bit_off <= off_d;
        end
    end

    // outputs: R7 framing
    always_comb begin
        frame = FRM_END;
        unique case (state)
            S_IDLE: frame = FRM_END;
            S_SEND: begin
                if (end_msg)        frame = FRM_END;
                else if (last_beat) frame = FRM_EOP;
                else                frame = FRM_BUSY;
            end
        endcase
    end

    // R10: an accepted request starts at the first bit of packet 0
    a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state == S_SEND && pkt_idx == '0 && bit_off == '0));

    // R7: closing a non-final packet moves to the next packet
    a_r7_eop_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEND && frame == FRM_EOP) |=>
            (state == S_SEND && pkt_idx == $past(pkt_idx) + IDX_W'(1) && bit_off == '0));

    // R3: a mid-packet beat stays in the same packet
    a_r3_mid_same_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEND && frame == FRM_BUSY) |=> (state == S_SEND && $stable(pkt_idx)));

    // R11: end of message without a request goes idle
    a_r11_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (end_msg && !in_valid) |=> (state == S_IDLE));

    // R9: handshake never accepted in the middle of a message
    a_r9_no_mid_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEND && frame != FRM_END) |-> !in_ready);
endmodule

// File: rtl/tm_packer.sv
module tm_packer #(
    parameter int BEAT_W  = 12,
    parameter int MAX_PKT = 2,
    parameter int FIX_W   = 8,
    parameter int VAR_W   = 32,
    localparam int CNT_W  = $clog2(MAX_PKT + 1),
    localparam int FLW    = $clog2(FIX_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [5:0]               in_type,
    input  logic [3:0]               in_src,
    input  logic [CNT_W-1:0]         in_pkt_cnt,
    input  logic [MAX_PKT*FIX_W-1:0] in_fix_data,
    input  logic [MAX_PKT*FLW-1:0]   in_fix_len,
    input  logic [MAX_PKT-1:0]       in_var_en,
    input  logic [MAX_PKT*VAR_W-1:0] in_var_data,
    output logic [BEAT_W-1:0]        out_data,
    output logic [1:0]               out_frame
);
    import tm_pkg::*;

    localparam int PKT_W = HDR_W + FIX_W + VAR_W;
    localparam int VEC_W = (PKT_W > BEAT_W) ? PKT_W : BEAT_W;
    localparam int LEN_W = $clog2(VEC_W + 1);
    localparam int IDX_W = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1;

    // latched request
    logic [HDR_W-1:0]         hdr_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [MAX_PKT*FIX_W-1:0] fix_q;
    logic [MAX_PKT*FLW-1:0]   flen_q;
    logic [MAX_PKT-1:0]       ven_q;
    logic [MAX_PKT*VAR_W-1:0] var_q;

    logic             take;
    state_t           state;
    logic [IDX_W-1:0] pkt_idx;
    logic [LEN_W-1:0] bit_off;
    logic [VEC_W-1:0] pkt_vec;
    logic [LEN_W-1:0] pkt_len;
    logic [VEC_W-1:0] shifted;
    logic [LEN_W-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            cnt_q  <= '0;
            fix_q  <= '0;
            flen_q <= '0;
            ven_q  <= '0;
            var_q  <= '0;
        end else if (take) begin
            hdr_q  <= {in_src, in_type};    // R2: type low, source above
            cnt_q  <= in_pkt_cnt;
            fix_q  <= in_fix_data;
            flen_q <= in_fix_len;
            ven_q  <= in_var_en;
            var_q  <= in_var_data;
        end
    end

    tm_pkt_build #(
        .FIX_W (FIX_W),
        .VAR_W (VAR_W),
        .FLW   (FLW),
        .VEC_W (VEC_W),
        .LEN_W (LEN_W)
    ) u_build (
        .first    (pkt_idx == '0),
        .hdr      (hdr_q),
        .fix_data (fix_q[32'(pkt_idx)*FIX_W +: FIX_W]),
        .fix_len  (flen_q[32'(pkt_idx)*FLW +: FLW]),
        .var_en   (ven_q[pkt_idx]),
        .var_data (var_q[32'(pkt_idx)*VAR_W +: VAR_W]),
        .vec      (pkt_vec),
        .len      (pkt_len)
    );

    tm_beat_fsm #(
        .BEAT_W  (BEAT_W),
        .MAX_PKT (MAX_PKT),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W),
        .LEN_W   (LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .pkt_cnt  (cnt_q),
        .pkt_len  (pkt_len),
        .in_ready (in_ready),
        .take     (take),
        .state    (state),
        .pkt_idx  (pkt_idx),
        .bit_off  (bit_off),
        .frame    (out_frame)
    );

    // R3: LSB-first beat slice; R1: zero data in idle
    always_comb begin
        shifted  = pkt_vec >> bit_off;
        rem      = pkt_len - bit_off;
        out_data = (state == S_SEND) ? shifted[BEAT_W-1:0] : '0;
    end

    // R6: padding above the packet's last bit is zero on closing beats
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEND && out_frame != FRM_BUSY) |-> ((VEC_W'(out_data) >> rem) == '0));

    // R1: idle code with zero data while not sending
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (out_frame == FRM_END && out_data == '0 && in_ready));
endmodule

// File: tb/sim_tm_packer.sv
module sim_tm_packer;
    localparam int BW  = 12;
    localparam int MP  = 3;
    localparam int FW  = 4;
    localparam int VW  = 12;
    localparam int CW  = 2;
    localparam int FLW = 3;
    localparam int NM  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [5:0]        in_type = '0;
    logic [3:0]        in_src = '0;
    logic [CW-1:0]     in_pkt_cnt = '0;
    logic [MP*FW-1:0]  in_fix_data = '0;
    logic [MP*FLW-1:0] in_fix_len = '0;
    logic [MP-1:0]     in_var_en = '0;
    logic [MP*VW-1:0]  in_var_data = '0;
    logic [BW-1:0]     out_data;
    logic [1:0]        out_frame;

    tm_packer #(.BEAT_W(BW), .MAX_PKT(MP), .FIX_W(FW), .VAR_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_type(in_type), .in_src(in_src), .in_pkt_cnt(in_pkt_cnt),
        .in_fix_data(in_fix_data), .in_fix_len(in_fix_len),
        .in_var_en(in_var_en), .in_var_data(in_var_data),
        .out_data(out_data), .out_frame(out_frame)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    // message store
    logic [5:0]    m_type [NM];
    logic [3:0]    m_src  [NM];
    logic [CW-1:0] m_cnt  [NM];
    logic [FW-1:0] m_fix  [NM][MP];
    logic [FLW-1:0] m_fl  [NM][MP];
    bit            m_ve   [NM][MP];
    logic [VW-1:0] m_var  [NM][MP];

    // expected beats of one message
    logic [BW-1:0] e_data  [16];
    logic [1:0]    e_frame [16];
    bit            e_first [16];
    bit            e_close [16];
    int            e_n;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic void build_exp(int m);
        bit sb [64];
        int n, pc, fl, sig, beats, idx;
        pc = (m_cnt[m] == 0) ? 1 : ((int'(m_cnt[m]) > MP) ? MP : int'(m_cnt[m]));
        e_n = 0;
        for (int p = 0; p < pc; p++) begin
            n = 0;
            if (p == 0) begin
                for (int i = 0; i < 6; i++) begin sb[n] = m_type[m][i]; n++; end
                for (int i = 0; i < 4; i++) begin sb[n] = m_src[m][i]; n++; end
            end
            fl = (int'(m_fl[m][p]) > FW) ? FW : int'(m_fl[m][p]);
            for (int i = 0; i < fl; i++) begin sb[n] = m_fix[m][p][i]; n++; end
            if (m_ve[m][p]) begin
                sig = VW;
                while (sig > 1 && !m_var[m][p][sig-1]) sig--;
                for (int i = 0; i < sig; i++) begin sb[n] = m_var[m][p][i]; n++; end
            end
            beats = (n == 0) ? 1 : (n + BW - 1) / BW;
            for (int k = 0; k < beats; k++) begin
                e_data[e_n] = '0;
                for (int j = 0; j < BW; j++) begin
                    idx = k * BW + j;
                    if (idx < n) e_data[e_n][j] = sb[idx];
                end
                e_frame[e_n] = (k == beats - 1) ? ((p == pc - 1) ? 2'b11 : 2'b01) : 2'b00;
                e_first[e_n] = (p == 0 && k == 0);
                e_close[e_n] = (k == beats - 1);
                e_n++;
            end
        end
    endfunction

    task automatic load(int m);
        in_type    = m_type[m];
        in_src     = m_src[m];
        in_pkt_cnt = m_cnt[m];
        for (int p = 0; p < MP; p++) begin
            in_fix_data[p*FW +: FW]   = m_fix[m][p];
            in_fix_len[p*FLW +: FLW]  = m_fl[m][p];
            in_var_en[p]              = m_ve[m][p];
            in_var_data[p*VW +: VW]   = m_var[m][p];
        end
        in_valid = 1'b1;
    endtask

    // mode 0 sweep, 1 variable lengths (R4), 2 fixed clamp (R5), 3 zero count (R8)
    task automatic gen(int n, int mode);
        for (int m = 0; m < n; m++) begin
            m_type[m] = 6'(rnd());
            m_src[m]  = 4'(rnd());
            m_cnt[m]  = CW'(1 + (m / 10) % 3);
            for (int p = 0; p < MP; p++) begin
                m_fix[m][p] = FW'(rnd());
                m_fl[m][p]  = FLW'((m + p) % 5);
                m_ve[m][p]  = ((m / 5 + p) % 2) == 1;
                m_var[m][p] = VW'(rnd() >> (rnd() % 13));
                if (mode == 1) begin
                    m_fl[m][p] = '0;
                    m_ve[m][p] = 1'b1;
                    case ((m + p) % 4)
                        0: m_var[m][p] = '0;
                        1: m_var[m][p] = VW'(1);
                        2: m_var[m][p] = '1;
                        default: m_var[m][p] = VW'(1) << (m % VW);
                    endcase
                end else if (mode == 2) begin
                    m_fl[m][p]  = FLW'(5 + (m + p) % 3);
                    m_fix[m][p] = '1;
                    m_ve[m][p]  = (m % 2) == 1;
                end
            end
            if (mode == 3) m_cnt[m] = '0;
        end
    endtask

    task automatic run(int n, bit chain, string hint);
        string tg;
        @(negedge clk);
        load(0);
        chk("R9 ready idle", 32'(in_ready), 1);
        @(negedge clk);
        for (int cur = 0; cur < n; cur++) begin
            build_exp(cur);
            if (chain && cur + 1 < n) load(cur + 1);
            else in_valid = 1'b0;
            for (int b = 0; b < e_n; b++) begin
                if (hint != "") tg = hint;
                else if (e_first[b]) tg = "R2";
                else if (e_close[b]) tg = "R6";
                else tg = "R3";
                chk({tg, " data"}, 32'(out_data), 32'(e_data[b]));
                chk("R7 frame", 32'(out_frame), 32'(e_frame[b]));
                chk("R9 ready", 32'(in_ready), (b == e_n - 1) ? 1 : 0);
                if (b < e_n - 1) @(negedge clk);
            end
            @(negedge clk);
            if (!(chain && cur + 1 < n)) begin
                chk("R11 idle frame", 32'(out_frame), 32'h3);
                chk("R1 idle data", 32'(out_data), 0);
                if (cur + 1 < n) begin
                    load(cur + 1);
                    chk("R9 ready idle", 32'(in_ready), 1);
                    @(negedge clk);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset frame", 32'(out_frame), 32'h3);
        chk("R1 reset data", 32'(out_data), 0);
        chk("R1 reset ready", 32'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle frame", 32'(out_frame), 32'h3);
        gen(40, 0); run(40, 1'b0, "");
        gen(24, 1); run(24, 1'b0, "R4");
        gen(18, 2); run(18, 1'b0, "R5");
        gen(8, 3);  run(8, 1'b0, "R8");
        gen(40, 0); run(40, 1'b1, "R10");
        repeat (2) @(negedge clk);
        chk("R11 final idle", 32'(out_frame), 32'h3);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule